// File: doc/BRIEF.md
# Flash Command Unlock Sequencer

This block sits behind the write path of a parallel flash controller and turns a stream of single write cycles into instruction starts for the program/erase engine. Each accepted write offers an address, a data value and a flag that says whether the bus is in byte or word organisation. Before any instruction is acted on, the block requires a fixed two-write unlock pattern. A command write then follows. Erase needs a second unlock pair before its confirm write.

The outputs are one-cycle start strobes: read-array, auto-select, program, block erase, chip erase, erase suspend and erase resume. For program and block erase the block also latches a target address, data and organisation flag. A level output tells the read path whether array data or identification data is to be returned. When a write does not fit the expected pattern, the sequence is dropped without any indication and the read path goes back to array data. While the engine reports busy, the only write the block acts on is a suspend.

Top module: `flash_cmd_seq`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, all strobes are low and `mode_o` is 0, which selects array reads (1 selects identification reads).
- R2: Unlock write one carries data AAh and unlock write two carries data 55h. Their addresses are 0AAAAh and 05555h in byte mode, compared on `wr_addr_i[15:0]`. In word mode they are 5555h and 2AAAh, compared on `wr_addr_i[14:0]`. Address bits above the compared field are ignored.
- R3: The third write must go to the unlock-one address. Data 90h pulses `auto_sel_o` and sets `mode_o` to 1. Data A0h arms program and data 80h arms erase, and neither pulses anything yet. Any other value (F0h excepted, see R6) fails as in R7.
- R4: The write after an armed program is taken as the target, whatever its address or data (F0h included). It pulses `prog_start_o` and latches `wr_addr_i`, `wr_data_i` and `byte_mode_i` onto `tgt_addr_o`, `tgt_data_o` and `tgt_byte_o`. `mode_o` returns to 0.
- R5: After an armed erase, writes four and five repeat the R2 unlock pair. Write six with data 10h at the unlock-one address pulses `chip_erase_o`. Write six with data 30h at any address pulses `blk_erase_o` and latches that address onto `tgt_addr_o`.
- R6: In every state except the program target slot, a write of data F0h at any address pulses `rd_array_o`, sets `mode_o` to 0 and restarts the sequence.
- R7: A write whose data or address does not fit the current step returns the sequence to its start and sets `mode_o` to 0, with no strobe.
- R8: While `busy_i` is 1, a B0h write pulses `suspend_o` only if `erasing_i` is 1. Every other write is ignored: no strobe, `mode_o` unchanged, and the position in the sequence kept.
- R9: With `busy_i` 0, `suspended_i` 1 and the sequence at its start, a 30h write at any address pulses `resume_o`. With `suspended_i` 0 the same write fails as in R7.
- R10: Each strobe rises in the clock cycle after the edge that samples the write, lasts one cycle, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up or supply loss) |
| wr_valid_i | input | 1 | A write cycle is presented this clock |
| wr_addr_i | input | ADDR_W | Write address (byte address in byte mode, word address in low bits in word mode) |
| wr_data_i | input | DATA_W | Write data; commands use bits [7:0] |
| byte_mode_i | input | 1 | 1 = byte organisation, 0 = word organisation |
| busy_i | input | 1 | Program/erase engine is running |
| erasing_i | input | 1 | The running operation is an erase |
| suspended_i | input | 1 | An erase is suspended |
| rd_array_o | output | 1 | Read-array start strobe |
| auto_sel_o | output | 1 | Auto-select start strobe |
| prog_start_o | output | 1 | Program start strobe |
| blk_erase_o | output | 1 | Block-erase confirm strobe |
| chip_erase_o | output | 1 | Chip-erase start strobe |
| suspend_o | output | 1 | Erase suspend strobe |
| resume_o | output | 1 | Erase resume strobe |
| mode_o | output | 1 | 0 = array reads, 1 = identification reads |
| tgt_addr_o | output | ADDR_W | Latched program or block-erase address |
| tgt_data_o | output | DATA_W | Latched program data |
| tgt_byte_o | output | 1 | Organisation flag latched with the target |

## Verification
Every possible third-write data value is swept in both organisations. This separates the two values that start something at once, the two that arm a longer sequence, and the rest, which must fail without a trace. Each address bit of both unlock writes is flipped one at a time, which confirms that exactly the compared field matters and that the bits above it do not. Directed sequences cover erase confirm in both forms, F0h in the middle of a sequence and in the program slot, writes while busy both with and without erase, and resume with and without a suspended erase.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ERS1, ST_ERS2, ST_ERSC
  } seq_state_e;

  typedef enum logic {MODE_ARRAY = 1'b0, MODE_IDENT = 1'b1} read_mode_e;

  localparam logic [7:0] CODE_UNL_A   = 8'hAA;
  localparam logic [7:0] CODE_UNL_B   = 8'h55;
  localparam logic [7:0] CODE_RESET   = 8'hF0;
  localparam logic [7:0] CODE_IDENT   = 8'h90;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_ERS_SET = 8'h80;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_BLK_RES = 8'h30;
  localparam logic [7:0] CODE_SUSP    = 8'hB0;

  typedef struct packed {
    logic unl_a;
    logic unl_b;
    logic reset;
    logic ident;
    logic prog;
    logic ers_set;
    logic chip;
    logic blk_res;
    logic susp;
  } code_hit_t;

  typedef struct packed {
    logic rd;
    logic ident;
    logic prog;
    logic blk;
    logic chip;
    logic susp;
    logic res;
  } strobe_t;
endpackage

// File: rtl/flash_addr_match.sv
module flash_addr_match #(
  parameter int unsigned UNLOCK_W    = 15,
  parameter int unsigned FIRST_WORD  = 'h5555,
  parameter int unsigned SECOND_WORD = 'h2AAA
) (
  input  logic [UNLOCK_W:0] addr_i,
  input  logic              byte_mode_i,
  output logic              at_first_o,
  output logic              at_second_o
);
  localparam logic [UNLOCK_W-1:0] FirstW  = FIRST_WORD[UNLOCK_W-1:0];
  localparam logic [UNLOCK_W-1:0] SecondW = SECOND_WORD[UNLOCK_W-1:0];
  // byte address = word address shifted up, lowest bit picks the half
  localparam logic [UNLOCK_W:0]   FirstB  = {FirstW, 1'b0};
  localparam logic [UNLOCK_W:0]   SecondB = {SecondW, 1'b1};

  always_comb begin
    if (byte_mode_i) begin
      at_first_o  = (addr_i == FirstB);
      at_second_o = (addr_i == SecondB);
    end else begin
      at_first_o  = (addr_i[UNLOCK_W-1:0] == FirstW);
      at_second_o = (addr_i[UNLOCK_W-1:0] == SecondW);
    end
  end
endmodule

// File: rtl/flash_code_decode.sv
module flash_code_decode
  import flash_seq_pkg::*;
(
  input  logic [7:0] code_i,
  output code_hit_t  hit_o
);
  always_comb begin
    hit_o.unl_a   = (code_i == CODE_UNL_A);
    hit_o.unl_b   = (code_i == CODE_UNL_B);
    hit_o.reset   = (code_i == CODE_RESET);
    hit_o.ident   = (code_i == CODE_IDENT);
    hit_o.prog    = (code_i == CODE_PROG);
    hit_o.ers_set = (code_i == CODE_ERS_SET);
    hit_o.chip    = (code_i == CODE_CHIP);
    hit_o.blk_res = (code_i == CODE_BLK_RES);
    hit_o.susp    = (code_i == CODE_SUSP);
  end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              byte_mode_i,
  input  logic              at_first_i,
  input  logic              at_second_i,
  input  code_hit_t         hit_i,
  input  logic              busy_i,
  input  logic              erasing_i,
  input  logic              suspended_i,
  output strobe_t           strobe_o,
  output logic              mode_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_data_o,
  output logic              tgt_byte_o
);
  seq_state_e st_q, st_d;
  read_mode_e mode_q, mode_d;
  strobe_t    stb_q, stb_d;
  logic       latch;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              byte_q;

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    stb_d  = '0;
    latch  = 1'b0;
    if (wr_valid_i) begin
      if (busy_i) begin
        // engine running: only suspend of an erase is honoured
        stb_d.susp = hit_i.susp & erasing_i;
      end else if (st_q == ST_PROG) begin
        stb_d.prog = 1'b1;
        latch      = 1'b1;
        st_d       = ST_IDLE;
        mode_d     = MODE_ARRAY;
      end else if (hit_i.reset) begin
        stb_d.rd = 1'b1;
        st_d     = ST_IDLE;
        mode_d   = MODE_ARRAY;
      end else begin
        st_d   = ST_IDLE;
        mode_d = MODE_ARRAY;
        unique case (st_q)
          ST_IDLE: begin
            if (hit_i.unl_a && at_first_i) begin
              st_d   = ST_UNL1;
              mode_d = mode_q;
            end else if (hit_i.blk_res && suspended_i) begin
              stb_d.res = 1'b1;
              mode_d    = mode_q;
            end
          end
          ST_UNL1: if (hit_i.unl_b && at_second_i) begin
            st_d   = ST_UNL2;
            mode_d = mode_q;
          end
          ST_UNL2: if (at_first_i) begin
            if (hit_i.ident) begin
              stb_d.ident = 1'b1;
              mode_d      = MODE_IDENT;
            end else if (hit_i.prog) begin
              st_d = ST_PROG;
            end else if (hit_i.ers_set) begin
              st_d = ST_ERS1;
            end
          end
          ST_ERS1: if (hit_i.unl_a && at_first_i) st_d = ST_ERS2;
          ST_ERS2: if (hit_i.unl_b && at_second_i) st_d = ST_ERSC;
          ST_ERSC: begin
            if (hit_i.chip && at_first_i) begin
              stb_d.chip = 1'b1;
            end else if (hit_i.blk_res) begin
              stb_d.blk = 1'b1;
              latch     = 1'b1;
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_ARRAY;
      stb_q  <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      stb_q  <= stb_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      byte_q <= 1'b0;
    end else if (latch) begin
      addr_q <= wr_addr_i;
      data_q <= wr_data_i;
      byte_q <= byte_mode_i;
    end
  end

  assign strobe_o   = stb_q;
  assign mode_o     = mode_q;
  assign tgt_addr_o = addr_q;
  assign tgt_data_o = data_q;
  assign tgt_byte_o = byte_q;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned UNLOCK_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              byte_mode_i,
  input  logic              busy_i,
  input  logic              erasing_i,
  input  logic              suspended_i,
  output logic              rd_array_o,
  output logic              auto_sel_o,
  output logic              prog_start_o,
  output logic              blk_erase_o,
  output logic              chip_erase_o,
  output logic              suspend_o,
  output logic              resume_o,
  output logic              mode_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_data_o,
  output logic              tgt_byte_o
);
  localparam int unsigned CmpW = UNLOCK_W + 1;

  logic      at_first, at_second;
  code_hit_t hit;
  strobe_t   stb;

  flash_addr_match #(.UNLOCK_W(UNLOCK_W)) u_match (
    .addr_i      (wr_addr_i[CmpW-1:0]),
    .byte_mode_i (byte_mode_i),
    .at_first_o  (at_first),
    .at_second_o (at_second)
  );

  flash_code_decode u_dec (
    .code_i (wr_data_i[7:0]),
    .hit_o  (hit)
  );

  flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .byte_mode_i (byte_mode_i),
    .at_first_i  (at_first),
    .at_second_i (at_second),
    .hit_i       (hit),
    .busy_i      (busy_i),
    .erasing_i   (erasing_i),
    .suspended_i (suspended_i),
    .strobe_o    (stb),
    .mode_o      (mode_o),
    .tgt_addr_o  (tgt_addr_o),
    .tgt_data_o  (tgt_data_o),
    .tgt_byte_o  (tgt_byte_o)
  );

  assign rd_array_o   = stb.rd;
  assign auto_sel_o   = stb.ident;
  assign prog_start_o = stb.prog;
  assign blk_erase_o  = stb.blk;
  assign chip_erase_o = stb.chip;
  assign suspend_o    = stb.susp;
  assign resume_o     = stb.res;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              busy_i,
  input logic              erasing_i,
  input logic              suspended_i,
  input logic              rd_array_o,
  input logic              auto_sel_o,
  input logic              prog_start_o,
  input logic              blk_erase_o,
  input logic              chip_erase_o,
  input logic              suspend_o,
  input logic              resume_o,
  input logic              mode_o,
  input logic [ADDR_W-1:0] tgt_addr_o,
  input logic [DATA_W-1:0] tgt_data_o
);
  logic [6:0] stb;
  assign stb = {rd_array_o, auto_sel_o, prog_start_o, blk_erase_o,
                chip_erase_o, suspend_o, resume_o};

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb)); // R10

  AST_NO_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> stb == '0); // R10

  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && busy_i && wr_data_i[7:0] != 8'hB0) |=> (stb == '0 && $stable(mode_o))); // R8

  AST_SUSPEND_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && busy_i && erasing_i && wr_data_i[7:0] == 8'hB0 |=> suspend_o); // R8

  AST_RESUME_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resume_o) |-> $past(suspended_i && !busy_i && wr_valid_i)); // R9

  AST_PROG_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_start_o) |-> (tgt_data_o == $past(wr_data_i) && tgt_addr_o == $past(wr_addr_i))); // R4

  AST_IDENT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_sel_o |-> mode_o); // R3

  AST_ARRAY_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_array_o || prog_start_o) |-> !mode_o); // R6
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .busy_i(busy_i), .erasing_i(erasing_i),
  .suspended_i(suspended_i), .rd_array_o(rd_array_o), .auto_sel_o(auto_sel_o),
  .prog_start_o(prog_start_o), .blk_erase_o(blk_erase_o),
  .chip_erase_o(chip_erase_o), .suspend_o(suspend_o), .resume_o(resume_o),
  .mode_o(mode_o), .tgt_addr_o(tgt_addr_o), .tgt_data_o(tgt_data_o)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wv = 1'b0, wb = 1'b0, busy = 1'b0, ersg = 1'b0, susp = 1'b0;
  logic [17:0] wa = '0;
  logic [15:0] wd = '0;
  logic rd, as_s, pg, be, ce, sp, rs, mode, tbyte;
  logic [17:0] taddr;
  logic [15:0] tdata;
  logic [6:0] snap;
  logic smode;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [6:0] S_RD = 7'b1000000, S_AS = 7'b0100000, S_PG = 7'b0010000,
                         S_BE = 7'b0001000, S_CE = 7'b0000100, S_SP = 7'b0000010,
                         S_RS = 7'b0000001;

  always #10 clk = ~clk;

  flash_cmd_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wv), .wr_addr_i(wa), .wr_data_i(wd),
    .byte_mode_i(wb), .busy_i(busy), .erasing_i(ersg), .suspended_i(susp),
    .rd_array_o(rd), .auto_sel_o(as_s), .prog_start_o(pg), .blk_erase_o(be),
    .chip_erase_o(ce), .suspend_o(sp), .resume_o(rs), .mode_o(mode),
    .tgt_addr_o(taddr), .tgt_data_o(tdata), .tgt_byte_o(tbyte)
  );

  function automatic logic [17:0] a1(input logic bm);
    return bm ? 18'h0AAAA : 18'h05555;
  endfunction
  function automatic logic [17:0] a2(input logic bm);
    return bm ? 18'h05555 : 18'h02AAA;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [15:0] d, input logic bm);
    @(negedge clk);
    wv = 1'b1; wa = a; wd = d; wb = bm;
    @(negedge clk);
    wv = 1'b0;
    snap  = {rd, as_s, pg, be, ce, sp, rs};
    smode = mode;
  endtask

  task automatic unlock(input logic bm);
    wr(a1(bm), 16'h00AA, bm);
    wr(a2(bm), 16'h0055, bm);
  endtask

  task automatic erase_pre(input logic bm);
    unlock(bm);
    wr(a1(bm), 16'h0080, bm);
    unlock(bm);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset strobes/mode", {rd, as_s, pg, be, ce, sp, rs, mode}, 8'h00);

    // R3 / R4: sweep every third-cycle value in both organisations
    for (int b = 0; b < 2; b++) begin
      for (int v = 0; v < 256; v++) begin
        logic bm;
        logic [6:0] es;
        bm = b[0];
        wr(a1(bm), 16'h00F0, bm);
        unlock(bm);
        wr(a1(bm), {8'h5A, v[7:0]}, bm);
        es = (v == 'hF0) ? S_RD : (v == 'h90) ? S_AS : 7'b0;
        chk("R3 third-cycle decode", {snap, smode}, {es, (v == 'h90)});
        if (v == 'hA0) begin
          wr(18'h12345 ^ {10'b0, v[7:0]}, 16'hC3F0, bm);
          chk("R4 program strobe", {snap, smode}, {S_PG, 1'b0});
          chk("R4 program target", {tbyte, taddr, tdata[11:0]},
              {bm, 18'h12345 ^ 18'hA0, 12'h3F0});
        end
      end
    end

    // R2: flip each address bit of either unlock write
    for (int b = 0; b < 2; b++) begin
      for (int j = 0; j < 2; j++) begin
        for (int i = 0; i < 18; i++) begin
          logic bm;
          logic [17:0] f;
          logic ok;
          bm = b[0];
          f  = 18'h1 << i;
          ok = bm ? (i >= 16) : (i >= 15);
          wr(a1(bm), 16'h00F0, bm);
          wr(a1(bm) ^ (j == 0 ? f : 18'h0), 16'h00AA, bm);
          wr(a2(bm) ^ (j == 1 ? f : 18'h0), 16'h0055, bm);
          wr(a1(bm), 16'h0090, bm);
          chk("R2 unlock address field", {25'b0, snap}, {25'b0, ok ? S_AS : 7'b0});
        end
      end
    end

    // R5: erase confirms
    for (int b = 0; b < 2; b++) begin
      logic bm;
      bm = b[0];
      wr(a1(bm), 16'h00F0, bm);
      erase_pre(bm);
      wr(a1(bm), 16'h0010, bm);
      chk("R5 chip erase", {25'b0, snap}, {25'b0, S_CE});
      erase_pre(bm);
      wr(18'h24680, 16'h0030, bm);
      chk("R5 block erase strobe", {25'b0, snap}, {25'b0, S_BE});
      chk("R5 block erase address", {14'b0, taddr}, {14'b0, 18'h24680});
      erase_pre(bm);
      wr(a2(bm), 16'h0010, bm);
      chk("R5 chip confirm off address", {25'b0, snap}, {25'b0, 7'b0});
    end
    unlock(1'b1);
    wr(a1(1'b1), 16'h0080, 1'b1);
    wr(a1(1'b1), 16'h00AA, 1'b1);
    wr(a1(1'b1), 16'h00AA, 1'b1);
    wr(a2(1'b1), 16'h0055, 1'b1);
    wr(a1(1'b1), 16'h0010, 1'b1);
    chk("R5 broken second pair", {25'b0, snap}, {25'b0, 7'b0});

    // R6: F0 anywhere mid-sequence, and inside program slot
    unlock(1'b0);
    wr(a1(1'b0), 16'h0090, 1'b0);
    wr(a1(1'b0), 16'h00AA, 1'b0);
    wr(18'h30001, 16'h00F0, 1'b0);
    chk("R6 reset mid-sequence", {snap, smode}, {S_RD, 1'b0});
    unlock(1'b0);
    wr(a1(1'b0), 16'h00A0, 1'b0);
    wr(18'h00077, 16'h00F0, 1'b0);
    chk("R4 F0 taken as program data", {snap, smode, tdata}, {S_PG, 1'b0, 16'h00F0});

    // R7: mismatch drops identification mode silently
    unlock(1'b1);
    wr(a1(1'b1), 16'h0090, 1'b1);
    chk("R3 ident mode set", {snap, smode}, {S_AS, 1'b1});
    wr(18'h00000, 16'h0012, 1'b1);
    chk("R7 mismatch back to array", {snap, smode}, {7'b0, 1'b0});
    unlock(1'b1);
    wr(18'h00000, 16'h0090, 1'b1);
    chk("R7 command at wrong address", {snap, smode}, {7'b0, 1'b0});

    // R8: busy behaviour
    unlock(1'b1);
    wr(a1(1'b1), 16'h0090, 1'b1);
    busy = 1'b1; ersg = 1'b1;
    wr(a1(1'b1), 16'h00F0, 1'b1);
    chk("R8 busy ignores reset", {snap, smode}, {7'b0, 1'b1});
    wr(18'h11111, 16'h00B0, 1'b1);
    chk("R8 suspend while erasing", {snap, smode}, {S_SP, 1'b1});
    ersg = 1'b0;
    wr(18'h11111, 16'h00B0, 1'b1);
    chk("R8 suspend ignored in program", {snap, smode}, {7'b0, 1'b1});
    busy = 1'b0;
    wr(a1(1'b1), 16'h00F0, 1'b1);
    unlock(1'b1);
    busy = 1'b1;
    wr(18'h00000, 16'h0000, 1'b1);
    busy = 1'b0;
    wr(a1(1'b1), 16'h0090, 1'b1);
    chk("R8 sequence position kept", {snap, smode}, {S_AS, 1'b1});

    // R9: resume
    susp = 1'b1;
    wr(18'h2F00F, 16'h0030, 1'b1);
    chk("R9 resume when suspended", {snap, smode}, {S_RS, 1'b1});
    susp = 1'b0;
    wr(18'h2F00F, 16'h0030, 1'b1);
    chk("R9 no resume without suspend", {snap, smode}, {7'b0, 1'b0});

    // R10: strobe lasts one cycle
    unlock(1'b0);
    wr(a1(1'b0), 16'h0090, 1'b0);
    @(negedge clk);
    chk("R10 strobe single cycle", {25'b0, rd, as_s, pg, be, ce, sp, rs}, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule